// File: doc/BRIEF.md
# Three-wire codec control serializer

This block drives a write-only, three-wire control bus of the kind used to program audio codecs: a mode line that tells the receiver what kind of byte follows, a data line, and a clock line that idles high. The host hands over one byte per request, together with the level the mode line must hold during that byte. A low level marks an address-type transfer and a high level marks a data-type transfer. The block then sequences the three pins on its own and raises a busy flag until the bus has settled back to idle.

Each transfer runs through five named states. In IDLE the bus rests with mode high, clock high and data low. An accepted request moves the block IDLE -> SETUP. SETUP drives the requested mode level with the clock high and data low for a fixed setup count. The transition SETUP -> LOW starts the first bit. Each bit is a LOW phase, where the clock is low and the data line shows the bit, followed by a HIGH phase, where the clock is high and the same bit is held. Both phases last one half-period count. After a HIGH phase the block goes HIGH -> LOW if more bits remain, or HIGH -> TAIL after the eighth bit. TAIL drives the idle levels for one more half-period with busy still high. The transition TAIL -> IDLE then releases busy.

The receiver samples on the rising clock edge. The setup count is derived from a clock frequency parameter and a minimum setup time in nanoseconds, and is rounded up.

Top module: `ctl3w_serializer`

## Requirements
- R1: Every accepted request produces exactly 8 falling edges on bus_clk before busy returns low.
- R2: Bits are sent least significant first: the value on bus_data at the k-th rising edge of bus_clk (k = 0..7) equals bit k of the accepted byte.
- R3: During the SETUP state, bus_mode equals the accepted req_mode, bus_clk is 1 and bus_data is 0. SETUP lasts SETUP_CYC = ceil(MODE_SETUP_NS * CLK_MHZ / 1000) cycles, which is 48 with the defaults of 250 MHz and 190 ns, before the first fall of bus_clk.
- R4: For each bit, bus_clk is 0 for HALF_CYC cycles (4 by default) and then 1 for HALF_CYC cycles, with bus_data constant across both phases.
- R5: After the eighth HIGH phase, the outputs are bus_mode=1, bus_clk=1 and bus_data=0 for HALF_CYC cycles with busy=1. Busy then drops, so one transfer keeps busy high for SETUP_CYC + 17*HALF_CYC cycles.
- R6: req_ready equals the inverse of busy. A request is accepted on a clock edge where req_valid and req_ready are both 1, and busy is 1 from the next cycle.
- R7: A request presented while busy is 1 is ignored. It does not alter the byte or the pin sequence in progress, and it does not start a transfer afterwards once its valid has been removed.
- R8: After reset, and whenever busy is 0, the outputs are bus_mode=1, bus_clk=1, bus_data=0, and busy is 0. An asynchronous reset during a transfer returns the block to this state.
- R9: The mode line keeps the requested level through SETUP and all bit phases. It changes only at the transitions IDLE -> SETUP and HIGH -> TAIL, never on a clock fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request (not busy) |
| req_byte | input | 8 | Byte to send |
| req_mode | input | 1 | Mode line level for this byte: 0 address-type, 1 data-type |
| busy | output | 1 | Transfer in progress, including the final idle half-period |
| bus_mode | output | 1 | Mode line to the codec |
| bus_data | output | 1 | Serial data line to the codec |
| bus_clk | output | 1 | Serial clock to the codec, idles high |

## Verification
On every cycle the assertions check the following:
- the idle pin levels whenever busy is low;
- data holding steady across each rising clock edge;
- the mode line never moving on a clock fall, and having been stable for the whole setup count before any fall;
- exactly eight clock falls per busy window;
- busy rising only after a valid request.

The exact setup and half-period lengths, the least-significant-first bit order for varied byte patterns and both mode levels, the tail length and the total busy window are shown only by the bench. The bench compares every cycle against a waveform computed from the requirements. The bench scenarios also cover rejection of a request made mid-transfer and recovery from a reset during a transfer.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
    localparam int BYTE_BITS = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_TAIL
    } ctl3w_state_e;
endpackage

// File: rtl/ctl3w_timer.sv
module ctl3w_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/ctl3w_shifter.sv
module ctl3w_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         shift,
    output logic         lsb
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= din;
        end else if (shift) begin
            sr_q <= sr_q >> 1;
        end
    end

    assign lsb = sr_q[0];
endmodule

// File: rtl/ctl3w_serializer.sv
module ctl3w_serializer
    import ctl3w_pkg::*;
#(
    parameter int CLK_MHZ       = 250,
    parameter int MODE_SETUP_NS = 190,
    parameter int HALF_CYC      = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [BYTE_BITS-1:0] req_byte,
    input  logic                 req_mode,
    output logic                 busy,
    output logic                 bus_mode,
    output logic                 bus_data,
    output logic                 bus_clk
);
    localparam int SETUP_RAW = (MODE_SETUP_NS * CLK_MHZ + 999) / 1000;
    localparam int SETUP_CYC = (SETUP_RAW < 1) ? 1 : SETUP_RAW;
    localparam int HALF_EFF  = (HALF_CYC < 1) ? 1 : HALF_CYC;
    localparam int MAX_CNT   = (SETUP_CYC > HALF_EFF) ? SETUP_CYC : HALF_EFF;
    localparam int CW        = $clog2(MAX_CNT + 1);
    localparam int BW        = $clog2(BYTE_BITS);

    ctl3w_state_e  state_q, state_d;
    logic [BW-1:0] bit_q;
    logic          mode_q;
    logic          accept;
    logic          tmr_load, tmr_expired;
    logic [CW-1:0] tmr_val;
    logic          sh_load, sh_shift, sh_lsb;
    logic          bit_inc;

    assign accept = req_valid && (state_q == ST_IDLE);

    ctl3w_timer #(.CW(CW)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    ctl3w_shifter #(.W(BYTE_BITS)) shifter_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sh_load),
        .din   (req_byte),
        .shift (sh_shift),
        .lsb   (sh_lsb)
    );

    // Next-state and sequencing controls
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        bit_inc  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d  = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(SETUP_CYC - 1);
                    sh_load  = 1'b1;
                end
            end
            ST_SETUP: begin
                if (tmr_expired) begin
                    state_d  = ST_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(HALF_EFF - 1);
                end
            end
            ST_LOW: begin
                if (tmr_expired) begin
                    state_d  = ST_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(HALF_EFF - 1);
                end
            end
            ST_HIGH: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    tmr_val  = CW'(HALF_EFF - 1);
                    if (bit_q == BW'(BYTE_BITS - 1)) begin
                        state_d = ST_TAIL;
                    end else begin
                        state_d  = ST_LOW;
                        sh_shift = 1'b1;
                        bit_inc  = 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                if (tmr_expired) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            mode_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            if (accept) begin
                bit_q  <= '0;
                mode_q <= req_mode;
            end else if (bit_inc) begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        req_ready = (state_q == ST_IDLE);
        bus_clk   = 1'b1;
        bus_data  = 1'b0;
        bus_mode  = 1'b1;
        unique case (state_q)
            ST_SETUP: bus_mode = mode_q;
            ST_LOW: begin
                bus_mode = mode_q;
                bus_clk  = 1'b0;
                bus_data = sh_lsb;
            end
            ST_HIGH: begin
                bus_mode = mode_q;
                bus_data = sh_lsb;
            end
            default: ;
        endcase
    end

    // Observation logic for the assertions below
    logic          clk_prev_q, mode_prev_q;
    logic [CW-1:0] mode_age_q;
    logic [3:0]    falls_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_prev_q  <= 1'b1;
            mode_prev_q <= 1'b1;
            mode_age_q  <= '0;
            falls_q     <= '0;
        end else begin
            clk_prev_q  <= bus_clk;
            mode_prev_q <= bus_mode;
            if (bus_mode != mode_prev_q) begin
                mode_age_q <= '0;
            end else if (mode_age_q != CW'(SETUP_CYC)) begin
                mode_age_q <= mode_age_q + 1'b1;
            end
            if (!busy) begin
                falls_q <= '0;
            end else if (clk_prev_q && !bus_clk) begin
                falls_q <= falls_q + 1'b1;
            end
        end
    end

    // R8
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_mode && bus_clk && !bus_data));

    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_clk) |-> $stable(bus_data));

    // R9
    mode_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_clk) |-> $stable(bus_mode));

    // R3: mode unchanged for the previous SETUP_CYC cycles at any clock fall
    mode_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_clk) |-> (mode_age_q >= CW'(SETUP_CYC - 1)));

    // R1
    eight_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (falls_q == 4'd8));

    // R6
    busy_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
endmodule

// File: tb/ctl3w_serializer_tb_top.sv
`timescale 1ns/1ps
module ctl3w_serializer_tb_top;
    localparam int S_EXP = 48;  // ceil(190 * 250 / 1000), R3
    localparam int H_EXP = 4;
    localparam int K_END = S_EXP + 17 * H_EXP;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [7:0] req_byte = 8'h00;
    logic       req_mode = 1'b0;
    logic       req_ready, busy, bus_mode, bus_data, bus_clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    ctl3w_serializer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_byte  (req_byte),
        .req_mode  (req_mode),
        .busy      (busy),
        .bus_mode  (bus_mode),
        .bus_data  (bus_data),
        .bus_clk   (bus_clk)
    );

    always #2 clk = ~clk;

    // {mode, byte}
    localparam logic [8:0] VEC [6] = '{
        {1'b0, 8'hA5}, {1'b1, 8'h01}, {1'b0, 8'h80},
        {1'b1, 8'hFF}, {1'b0, 8'h00}, {1'b1, 8'h3C}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    // Walk one transfer cycle by cycle; vectors are {mode, clk, data, busy}
    task automatic run_xfer(input logic [7:0] b, input logic m, input bit inject);
        bit         err [5];
        int         act_v [5];
        int         exp_v [5];
        logic [7:0] rx = 8'h00;
        int         nb = 0;
        int         falls = 0;
        logic       prev_clk = 1'b1;
        for (int i = 0; i < 5; i++) begin
            err[i] = 0; act_v[i] = 0; exp_v[i] = 0;
        end
        @(negedge clk);
        req_valid = 1'b1; req_byte = b; req_mode = m;
        for (int k = 1; k <= K_END + 3; k++) begin
            int   cat;
            int   p;
            logic em, ec, ed, eb;
            logic [3:0] av, ev;
            @(negedge clk);
            if (k == 1) req_valid = 1'b0;
            if (inject && k == 20) begin
                req_valid = 1'b1; req_byte = ~b; req_mode = ~m;
            end
            if (inject && k == 21) req_valid = 1'b0;
            p = k - 1;
            if (p < S_EXP) begin
                cat = 0; em = m; ec = 1; ed = 0; eb = 1;
            end else if (p < S_EXP + 16 * H_EXP) begin
                int q = p - S_EXP;
                int bi = q / (2 * H_EXP);
                cat = 1; em = m; eb = 1; ed = b[bi];
                ec = ((q % (2 * H_EXP)) >= H_EXP);
            end else if (p < K_END) begin
                cat = 2; em = 1; ec = 1; ed = 0; eb = 1;
            end else begin
                cat = 3; em = 1; ec = 1; ed = 0; eb = 0;
            end
            av = {bus_mode, bus_clk, bus_data, busy};
            ev = {em, ec, ed, eb};
            if (av != ev && !err[cat]) begin
                err[cat] = 1; act_v[cat] = av; exp_v[cat] = ev;
            end
            if (cat == 1 && bus_mode != m && !err[4]) begin
                err[4] = 1; act_v[4] = bus_mode; exp_v[4] = m;
            end
            if (req_ready != !busy && !err[3]) begin
                err[3] = 1; act_v[3] = req_ready; exp_v[3] = !busy;
            end
            if (bus_clk && !prev_clk && nb < 8) begin
                rx[nb] = bus_data; nb++;
            end
            if (!bus_clk && prev_clk) falls++;
            prev_clk = bus_clk;
        end
        chk(!err[0], "R3", "setup phase", act_v[0], exp_v[0]);
        chk(!err[1], "R4", "bit phases", act_v[1], exp_v[1]);
        chk(!err[2], "R5", "tail phase", act_v[2], exp_v[2]);
        chk(!err[3], "R6", "busy/ready window", act_v[3], exp_v[3]);
        chk(!err[4], "R9", "mode level during bits", act_v[4], exp_v[4]);
        chk(rx == b, "R2", "decoded byte LSB first", rx, b);
        chk(falls == 8, "R1", "clock falls", falls, 8);
        if (inject) begin
            chk(rx == b && !err[3], "R7", "request while busy ignored", rx, b);
        end
    endtask

    initial begin
        #1;
        // R8: outputs in reset
        chk({bus_mode, bus_clk, bus_data, busy} == 4'b1100, "R8", "reset outputs",
            {bus_mode, bus_clk, bus_data, busy}, 4'b1100);
        chk(req_ready == 1'b1, "R6", "ready in reset", req_ready, 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({bus_mode, bus_clk, bus_data, busy} == 4'b1100, "R8", "idle after reset",
            {bus_mode, bus_clk, bus_data, busy}, 4'b1100);

        for (int v = 0; v < 6; v++) begin
            run_xfer(VEC[v][7:0], VEC[v][8], 1'b0);
        end

        // R7: a request pulsed mid-transfer
        run_xfer(8'h96, 1'b0, 1'b1);

        // R8: reset in the middle of a transfer
        @(negedge clk);
        req_valid = 1'b1; req_byte = 8'h5A; req_mode = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (60) @(negedge clk);
        chk(bus_clk == 1'b0 || busy == 1'b1, "R8", "transfer under way before reset", busy, 1);
        rst_n = 1'b0;
        #1;
        chk({bus_mode, bus_clk, bus_data, busy} == 4'b1100, "R8", "idle on mid-transfer reset",
            {bus_mode, bus_clk, bus_data, busy}, 4'b1100);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(req_ready == 1'b1 && busy == 1'b0, "R6", "ready after recovery", req_ready, 1);

        finish_run();
    end
endmodule